// File: doc/BRIEF.md
# System Bus Address Decoder with Boot Remap

This block is the first-stage target selector of a 32-bit system bus. Each cycle, a master presents an address together with valid and write qualifiers. The decoder names exactly one target on a one-hot select vector. The possible targets are:

- six external chip selects
- the DRAM controller
- the peripheral bridge
- the internal memory regions

The top four address bits pick one of sixteen 256 MB banks. Bank 0, the internal memory bank, is decoded a second time into 1 MB regions using the next eight address bits. An address with no target gets no select and is answered with a two-cycle error response.

Address zero is special. After reset it aliases the boot source, which a strap input sets to either the on-chip ROM or external chip select 0. A control write then sets a remap flag, and from then on internal SRAM also appears at address zero. A separate restore bit, or a reset, clears the flag again. A configuration input can add one wait state after every accepted access to the two tightly coupled memory windows.

Top module: `addr_decode_remap`

## Requirements
- R1: An accepted transfer to bank `n`, for `n` from 1 to 6 (address bits [31:28]), asserts `slave_sel[n-1]`, which is external chip select `n-1`, and no other select bit.
- R2: An accepted transfer to bank 7 asserts `slave_sel[6]` (DRAM). An accepted transfer to bank 15 asserts `slave_sel[13]` (peripheral bridge).
- R3: In bank 0, address bits [27:20] pick the internal region, and each region drives one select bit:

  | Region | Target | `slave_sel` bit |
  |---|---|---|
  | 1 | ROM | 7 |
  | 2 | instruction TCM window | 9 |
  | 3 | SRAM | 8 |
  | 4 | data TCM window | 10 |
  | 5 | USB RAM | 11 |
  | 6 | display buffer | 12 |

- R4: An accepted transfer to an unmapped location asserts no select bit. Unmapped locations are banks 8 to 14, and regions 7 to 255 of bank 0. The response that follows is `resp_err`=1 with `resp_ready`=0 in the next cycle, then `resp_err`=1 with `resp_ready`=1 in the cycle after, then `resp_err`=0.
- R5: While remap is off, region 0 of bank 0 selects the ROM (bit 7) when `boot_from_ext`=0, and external chip select 0 (bit 0) when `boot_from_ext`=1.
- R6: A cycle with `remap_wr`=1 and `remap_wdata`=2'b01 turns remap on from the next cycle. Region 0 then selects SRAM (bit 8) whatever the strap says, and region 3 still selects SRAM.
- R7: `remap_wdata[1]`=1 on a control write turns remap off, and it wins over bit 0 when both are set. A control write with both bits 0 leaves remap unchanged.
- R8: With `tcm_wait_en`=1, an accepted access to region 2 or region 4 is followed by one cycle with `resp_ready`=0 and `resp_err`=0. With `tcm_wait_en`=0, or for any other target, `resp_ready` stays 1.
- R9: A transfer is accepted only when `trans_valid`=1 and `resp_ready`=1. Otherwise `slave_sel` is all zero and the transfer has no effect on the response.
- R10: Decoding is the same for reads (`trans_write`=0) and writes (`trans_write`=1).
- R11: While reset is held, and after it is released, the outputs are `slave_sel`=0, `resp_ready`=1 and `resp_err`=0, and remap is off. A reset taken while remap is on restores the boot mapping of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trans_valid | input | 1 | A transfer is presented this cycle |
| trans_write | input | 1 | Transfer direction (1 = write) |
| trans_addr | input | 32 | Transfer byte address |
| boot_from_ext | input | 1 | Boot strap: 0 = ROM at address zero, 1 = external chip select 0 |
| tcm_wait_en | input | 1 | Add one wait state after tightly coupled memory accesses |
| remap_wr | input | 1 | Control write strobe for the remap flag |
| remap_wdata | input | 2 | Bit 0 = set remap, bit 1 = restore boot mapping |
| slave_sel | output | 14 | One-hot target select for the accepted transfer |
| resp_ready | output | 1 | Response ready; low during the first error cycle and the wait state |
| resp_err | output | 1 | Error response for an unmapped transfer (two cycles) |

## Verification
The bench walks every mapped bank and every named region of bank 0. This separates first-level from second-level decoding, and shows that the select bit for each target is placed correctly. It also probes unmapped banks and high region numbers, including a transfer offered during each of the two error cycles. That contrast shows the ignored first error cycle apart from the accepting second one.

Address zero is read under both strap values, before and after remap, after a restore, after a combined set-and-restore write and after a reset. This shows that the remap flag, and not the strap, owns the alias. Back-to-back accesses to the TCM windows, with and without the wait enable and against SRAM, confirm that the stall belongs only to those windows.

// File: rtl/addr_dec_pkg.sv
`timescale 1ns/1ps
package addr_dec_pkg;
  // Target indices inside the one-hot select vector
  localparam int NUM_EXT_CS  = 6;
  localparam int SEL_EXT0    = 0;
  localparam int SEL_DRAM    = 6;
  localparam int SEL_ROM     = 7;
  localparam int SEL_SRAM    = 8;
  localparam int SEL_ITCM    = 9;
  localparam int SEL_DTCM    = 10;
  localparam int SEL_USBRAM  = 11;
  localparam int SEL_DISP    = 12;
  localparam int SEL_PERIPH  = 13;
  localparam int NUM_SEL     = 14;

  // First-level bank numbers
  localparam int BANK_INT       = 0;
  localparam int BANK_EXT_FIRST = 1;
  localparam int BANK_DRAM      = 7;
  localparam int BANK_PERIPH    = 15;

  // Second-level region numbers inside the internal bank
  localparam int RG_BOOT = 0;
  localparam int RG_ROM  = 1;
  localparam int RG_ITCM = 2;
  localparam int RG_SRAM = 3;
  localparam int RG_DTCM = 4;
  localparam int RG_USB  = 5;
  localparam int RG_DISP = 6;

  typedef logic [NUM_SEL-1:0] sel_vec_t;

  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_ERR_A = 2'd1,
    RSP_ERR_B = 2'd2,
    RSP_STALL = 2'd3
  } rsp_state_e;
endpackage

// File: rtl/adec_rst_sync.sv
`timescale 1ns/1ps
module adec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/adec_bank_decode.sv
`timescale 1ns/1ps
module adec_bank_decode
  import addr_dec_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic [BANK_W-1:0] bank,
  output sel_vec_t          bank_sel,
  output logic              bank_hit,
  output logic              bank_internal
);
  sel_vec_t ext_sel;

  // One comparator per external chip select, banks numbered consecutively
  for (genvar i = 0; i < NUM_EXT_CS; i++) begin : g_ext
    assign ext_sel[SEL_EXT0+i] = (bank == BANK_W'(BANK_EXT_FIRST + i));
  end
  assign ext_sel[NUM_SEL-1:NUM_EXT_CS] = '0;

  always_comb begin
    bank_sel             = ext_sel;
    bank_sel[SEL_DRAM]   = (bank == BANK_W'(BANK_DRAM));
    bank_sel[SEL_PERIPH] = (bank == BANK_W'(BANK_PERIPH));
    bank_internal        = (bank == BANK_W'(BANK_INT));
    bank_hit             = |bank_sel;
  end
endmodule

// File: rtl/adec_region_decode.sv
`timescale 1ns/1ps
module adec_region_decode
  import addr_dec_pkg::*;
#(
  parameter int REGION_W = 8
) (
  input  logic [REGION_W-1:0] region,
  input  logic                remap_on,
  input  logic                boot_from_ext,
  output sel_vec_t            rg_sel,
  output logic                rg_hit,
  output logic                rg_tcm
);
  always_comb begin
    rg_sel = '0;
    if (region == REGION_W'(RG_BOOT)) begin
      // Address zero alias: remap flag first, then boot strap
      if (remap_on)           rg_sel[SEL_SRAM] = 1'b1;
      else if (boot_from_ext) rg_sel[SEL_EXT0] = 1'b1;
      else                    rg_sel[SEL_ROM]  = 1'b1;
    end else if (region == REGION_W'(RG_ROM)) begin
      rg_sel[SEL_ROM] = 1'b1;
    end else if (region == REGION_W'(RG_ITCM)) begin
      rg_sel[SEL_ITCM] = 1'b1;
    end else if (region == REGION_W'(RG_SRAM)) begin
      rg_sel[SEL_SRAM] = 1'b1;
    end else if (region == REGION_W'(RG_DTCM)) begin
      rg_sel[SEL_DTCM] = 1'b1;
    end else if (region == REGION_W'(RG_USB)) begin
      rg_sel[SEL_USBRAM] = 1'b1;
    end else if (region == REGION_W'(RG_DISP)) begin
      rg_sel[SEL_DISP] = 1'b1;
    end
    rg_hit = |rg_sel;
    rg_tcm = rg_sel[SEL_ITCM] | rg_sel[SEL_DTCM];
  end
endmodule

// File: rtl/adec_remap_ctrl.sv
`timescale 1ns/1ps
module adec_remap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_set,
  input  logic ctl_restore,
  output logic remap_on
);
  logic remap_q, remap_d, remap_en;

  assign remap_en = ctl_wr;

  always_comb begin
    remap_d = remap_q;
    if (ctl_restore)  remap_d = 1'b0;
    else if (ctl_set) remap_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        remap_q <= 1'b0;
    else if (remap_en) remap_q <= remap_d;
  end

  assign remap_on = remap_q;

  assert_remap_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_set && !ctl_restore) |=> remap_on);
  assert_restore_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_restore) |=> !remap_on);
  assert_remap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr || (!ctl_set && !ctl_restore)) |=> $stable(remap_on));
endmodule

// File: rtl/adec_resp_ctrl.sv
`timescale 1ns/1ps
module adec_resp_ctrl
  import addr_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic miss,
  input  logic tcm_hit,
  input  logic stall_en,
  output logic ready,
  output logic err
);
  rsp_state_e state_q, state_d;

  always_comb begin
    state_d = RSP_IDLE;
    unique case (state_q)
      RSP_ERR_A: state_d = RSP_ERR_B;
      RSP_STALL: state_d = RSP_IDLE;
      default: begin
        if (accept && miss)                     state_d = RSP_ERR_A;
        else if (accept && tcm_hit && stall_en) state_d = RSP_STALL;
        else                                    state_d = RSP_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RSP_IDLE;
    else        state_q <= state_d;
  end

  assign ready = (state_q != RSP_ERR_A) && (state_q != RSP_STALL);
  assign err   = (state_q == RSP_ERR_A) || (state_q == RSP_ERR_B);

  assert_err_second_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !ready) |=> (err && ready));
  assert_err_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && miss) |=> (err && !ready));
  assert_tcm_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tcm_hit && stall_en && !miss) |=> (!ready && !err));
  assert_stall_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !err) |=> ready);
endmodule

// File: rtl/addr_decode_remap.sv
`timescale 1ns/1ps
module addr_decode_remap
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BANK_W   = 4,
  parameter int REGION_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trans_valid,
  input  logic              trans_write,
  input  logic [ADDR_W-1:0] trans_addr,
  input  logic              boot_from_ext,
  input  logic              tcm_wait_en,
  input  logic              remap_wr,
  input  logic [1:0]        remap_wdata,
  output logic [13:0]       slave_sel,
  output logic              resp_ready,
  output logic              resp_err
);
  localparam int BANK_LSB   = ADDR_W - BANK_W;
  localparam int REGION_LSB = BANK_LSB - REGION_W;

  logic                rst_n_sync;
  logic [BANK_W-1:0]   bank;
  logic [REGION_W-1:0] region;
  sel_vec_t            bank_sel, rg_sel, sel_raw;
  logic                bank_hit, bank_internal, rg_hit, rg_tcm;
  logic                remap_on, accept, hit, tcm_hit;
  logic                addr_lo_unused;

  assign bank   = trans_addr[ADDR_W-1:BANK_LSB];
  assign region = trans_addr[BANK_LSB-1:REGION_LSB];
  // Direction and in-region offset do not take part in decoding
  assign addr_lo_unused = ^{trans_write, trans_addr[REGION_LSB-1:0]};

  adec_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  adec_bank_decode #(.BANK_W(BANK_W)) u_bank (
    .bank          (bank),
    .bank_sel      (bank_sel),
    .bank_hit      (bank_hit),
    .bank_internal (bank_internal)
  );

  adec_region_decode #(.REGION_W(REGION_W)) u_region (
    .region        (region),
    .remap_on      (remap_on),
    .boot_from_ext (boot_from_ext),
    .rg_sel        (rg_sel),
    .rg_hit        (rg_hit),
    .rg_tcm        (rg_tcm)
  );

  adec_remap_ctrl u_remap (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .ctl_wr      (remap_wr),
    .ctl_set     (remap_wdata[0]),
    .ctl_restore (remap_wdata[1]),
    .remap_on    (remap_on)
  );

  assign sel_raw = bank_internal ? rg_sel : bank_sel;
  assign hit     = bank_internal ? rg_hit : bank_hit;
  assign tcm_hit = bank_internal & rg_tcm;
  assign accept  = trans_valid & resp_ready;

  adec_resp_ctrl u_resp (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .accept   (accept),
    .miss     (~hit),
    .tcm_hit  (tcm_hit),
    .stall_en (tcm_wait_en),
    .ready    (resp_ready),
    .err      (resp_err)
  );

  assign slave_sel = (accept && hit) ? sel_raw : '0;

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0(slave_sel));
  assert_no_sel_unless_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(trans_valid && resp_ready) |-> (slave_sel == '0));
  assert_miss_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (trans_valid && resp_ready && slave_sel == '0) |=> (resp_err && !resp_ready));
endmodule

// File: tb/addr_decode_remap_tb.sv
`timescale 1ns/1ps
module addr_decode_remap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trans_valid = 1'b0, trans_write = 1'b0;
  logic [31:0] trans_addr = '0;
  logic        boot_from_ext = 1'b0, tcm_wait_en = 1'b0, remap_wr = 1'b0;
  logic [1:0]  remap_wdata = '0;
  logic [13:0] slave_sel;
  logic        resp_ready, resp_err;

  always #4 clk = ~clk;  // 125 MHz

  addr_decode_remap u_dut (
    .clk(clk), .rst_n(rst_n), .trans_valid(trans_valid), .trans_write(trans_write),
    .trans_addr(trans_addr), .boot_from_ext(boot_from_ext), .tcm_wait_en(tcm_wait_en),
    .remap_wr(remap_wr), .remap_wdata(remap_wdata), .slave_sel(slave_sel),
    .resp_ready(resp_ready), .resp_err(resp_err)
  );

  typedef struct {
    logic [13:0] sel;
    logic        rdy;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 0;
  bit   m_remap = 0, m_strap = 0, m_wait = 0;
  int   m_phase = 0;  // 0 idle, 1 first error cycle, 2 second error cycle, 3 wait state

  // Expected map from the requirements: {tcm, hit, sel[13:0]}
  function automatic logic [15:0] ref_map(logic [31:0] a, bit remap, bit strap);
    logic [13:0] s;
    int b, r;
    s = '0;
    b = int'(a[31:28]);
    r = int'(a[27:20]);
    if (b >= 1 && b <= 6) s[b-1] = 1'b1;
    else if (b == 7)      s[6]   = 1'b1;
    else if (b == 15)     s[13]  = 1'b1;
    else if (b == 0) begin
      case (r)
        0: s[remap ? 8 : (strap ? 0 : 7)] = 1'b1;
        1: s[7]  = 1'b1;
        2: s[9]  = 1'b1;
        3: s[8]  = 1'b1;
        4: s[10] = 1'b1;
        5: s[11] = 1'b1;
        6: s[12] = 1'b1;
        default: ;
      endcase
    end
    return {s[9] | s[10], |s, s};
  endfunction

  task automatic step(bit v, bit w, logic [31:0] a, bit cw, logic [1:0] cd, string tag);
    logic [15:0] m;
    exp_t e;
    bit acc;
    trans_valid = v; trans_write = w; trans_addr = a;
    remap_wr = cw; remap_wdata = cd;
    boot_from_ext = m_strap; tcm_wait_en = m_wait;
    m = ref_map(a, m_remap, m_strap);
    e.rdy = !(m_phase == 1 || m_phase == 3);
    e.err = (m_phase == 1 || m_phase == 2);
    acc   = v && e.rdy;
    e.sel = acc ? m[13:0] : 14'h0;
    e.tag = tag;
    exp_q.push_back(e);
    if (m_phase == 1)                 m_phase = 2;
    else if (acc && !m[14])           m_phase = 1;
    else if (acc && m[15] && m_wait)  m_phase = 3;
    else                              m_phase = 0;
    if (cw) begin
      if (cd[1])      m_remap = 0;
      else if (cd[0]) m_remap = 1;
    end
    @(posedge clk); #1;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 32'h0, 0, 2'b00, tag);
  endtask

  // Monitor: pops one expected item per cycle, compares away from the edge
  always @(negedge clk) begin : mon
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_cmp++;
      if (slave_sel !== e.sel || resp_ready !== e.rdy || resp_err !== e.err) begin
        n_bad++;
        $display("FAIL %s: sel=%h rdy=%b err=%b expected sel=%h rdy=%b err=%b",
                 e.tag, slave_sel, resp_ready, resp_err, e.sel, e.rdy, e.err);
      end
    end
  end

  task automatic do_reset();
    rst_n = 0; trans_valid = 0; trans_write = 0; trans_addr = '0;
    remap_wr = 0; remap_wdata = '0;
    m_remap = 0; m_phase = 0;
    @(posedge clk); @(negedge clk);
    n_cmp++;  // R11 outputs while reset is held
    if (slave_sel !== 14'h0 || resp_ready !== 1'b1 || resp_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: sel=%h rdy=%b err=%b expected sel=0000 rdy=1 err=0",
               slave_sel, resp_ready, resp_err);
    end
    @(posedge clk); #1;
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    idle(2, "R11");

    // R1: external chip selects
    for (int b = 1; b <= 6; b++) step(1, 0, {4'(b), 28'h0123456}, 0, 2'b00, "R1");
    // R2: DRAM and peripheral bridge
    step(1, 0, 32'h7ABC_0000, 0, 2'b00, "R2");
    step(1, 0, 32'hFFFF_F400, 0, 2'b00, "R2");
    // R3: internal regions
    for (int r = 1; r <= 6; r++) step(1, 0, {4'h0, 8'(r), 20'h00F0}, 0, 2'b00, "R3");

    // R4 / R9: unmapped region, transfers offered during both error cycles
    step(1, 0, 32'h0070_0000, 0, 2'b00, "R4");
    step(1, 0, 32'h1000_0000, 0, 2'b00, "R9");
    step(1, 0, 32'h1000_0000, 0, 2'b00, "R4");
    idle(2, "R4");
    step(1, 0, 32'h0FF0_0000, 0, 2'b00, "R4");
    idle(3, "R4");
    for (int b = 8; b <= 14; b++) begin
      step(1, 0, {4'(b), 28'h0000010}, 0, 2'b00, "R4");
      idle(2, "R4");
    end

    // R5: boot strap selects the zero alias
    m_strap = 0; step(1, 0, 32'h0000_0000, 0, 2'b00, "R5");
    m_strap = 1; step(1, 0, 32'h0000_0040, 0, 2'b00, "R5");
    m_strap = 0;

    // R10: writes decode like reads
    step(1, 1, 32'h3000_0004, 0, 2'b00, "R10");
    step(1, 1, 32'h0040_0000, 0, 2'b00, "R10");

    // R6: remap on
    step(0, 0, 32'h0, 1, 2'b01, "R6");
    step(1, 0, 32'h0000_0000, 0, 2'b00, "R6");
    step(1, 0, 32'h0030_0000, 0, 2'b00, "R6");
    m_strap = 1; step(1, 0, 32'h0000_0100, 0, 2'b00, "R6");
    m_strap = 0;

    // R7: no-op write, restore, restore wins over set
    step(0, 0, 32'h0, 1, 2'b00, "R7");
    step(1, 0, 32'h0000_0000, 0, 2'b00, "R7");
    step(0, 0, 32'h0, 1, 2'b10, "R7");
    step(1, 0, 32'h0000_0000, 0, 2'b00, "R7");
    step(0, 0, 32'h0, 1, 2'b01, "R7");
    step(0, 0, 32'h0, 1, 2'b11, "R7");
    step(1, 0, 32'h0000_0000, 0, 2'b00, "R7");

    // R8: wait state on TCM windows only
    m_wait = 1;
    step(1, 0, 32'h0020_0000, 0, 2'b00, "R8");
    step(1, 0, 32'h0020_0000, 0, 2'b00, "R8");
    step(1, 0, 32'h0040_0008, 0, 2'b00, "R8");
    step(1, 0, 32'h0030_0000, 0, 2'b00, "R8");
    step(1, 0, 32'h0030_0000, 0, 2'b00, "R8");
    idle(2, "R8");
    m_wait = 0;
    step(1, 0, 32'h0020_0000, 0, 2'b00, "R8");
    step(1, 0, 32'h0040_0000, 0, 2'b00, "R8");

    // R9: no select without valid
    step(0, 0, 32'h1000_0000, 0, 2'b00, "R9");
    step(0, 0, 32'h0900_0000, 0, 2'b00, "R9");

    // R11: reset clears remap
    step(0, 0, 32'h0, 1, 2'b01, "R11");
    step(1, 0, 32'h0000_0000, 0, 2'b00, "R11");
    idle(1, "R11");
    do_reset();
    step(1, 0, 32'h0000_0000, 0, 2'b00, "R11");
    idle(2, "R11");

    finished = 1;
    summary();
    $finish;
  end
endmodule